// File: doc/BRIEF.md
# Protected Byte-Wide Nonvolatile Memory Controller

This block is the control and storage model of a byte-wide nonvolatile memory. A host drives active-low chip-enable, output-enable and write-enable strobes with an address and a data byte. Each accepted write is committed to a small register array and then starts an internal programming interval. During that interval the part reports itself as busy. A host that polls by reading sees data bit 6 invert from one read to the next, and it stops inverting when the interval ends.

Writes are guarded in two ways. In hardware, a write is refused unless the strobes are in the write pattern and the supply-good flag is high. In software, a lock bit can be set. While it is set, a data write is taken only when a three-write command prefix comes immediately before it. The lock is cleared only by a six-write release sequence or by a factory reset. Dropping the supply flag does not clear it, so it behaves as nonvolatile state.

Top module: `nv_protect_mem`

## Requirements
- R1: After factory reset (`rstN` low), `busy` and `commitStrobe` are 0, the lock is clear, and `rdData` is 0 whenever no read is active (a read is active when `ceN`=0, `oeN`=0 and `weN`=1).
- R2: A write is recognised only on the first cycle of `ceN`=0, `weN`=0, `oeN`=1. With `oeN` low, or `weN` high, or `ceN` high, nothing is committed and the array is unchanged.
- R3: While `supplyOk` is 0, no write is committed and the array is unchanged.
- R4: With the lock clear, a plain write pulses `commitStrobe` in the cycle it is recognised, and the byte is stored at array index `addr` modulo `MEM_DEPTH`.
- R5: After a commit, `busy` is high for exactly `WRITE_CYCLES` cycles. Every write recognised while `busy` is high is ignored.
- R6: While `busy` is high, bit 6 of each read returns the inverse of bit 6 from the previous read.
- R7: Once `busy` is low, reads return the stored byte, and repeated reads return the same value.
- R8: The writes 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 arm the next write. These three command writes commit nothing. The armed write commits its byte and sets the lock.
- R9: While the lock is set, a write that is not preceded by the arming prefix is ignored.
- R10: While the lock is set, the arming prefix followed by a data write commits that write, and the lock stays set.
- R11: A write that does not match the next expected command step aborts the sequence. That write is then treated as a plain write.
- R12: The lock persists through an interval in which `supplyOk` is 0.
- R13: The six writes 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x20/0x5555 clear the lock and commit nothing. Plain writes are accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low factory reset (clears the array and the lock) |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| supplyOk | input | 1 | High when the supply is above the write threshold |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; 0 when no read is active |
| commitStrobe | output | 1 | One-cycle pulse when a byte is written to the array |
| busy | output | 1 | High during the internal write interval |

## Verification
The bench builds the block with `WRITE_CYCLES`=12 and the default `MEM_DEPTH`=64 and `ADDR_W`=15. A 12-cycle interval is long enough to fit a rejected write and two polling reads inside one busy window, and short enough to count its exact length on every test. A 15-bit address keeps the full command addresses 0x5555 and 0x2AAA, while data bytes go to low addresses that sit inside the 64-entry array.

// File: rtl/nv_protect_pkg.sv
package nv_protect_pkg;
  localparam int DATA_W     = 8;
  localparam int TOGGLE_BIT = 6;

  localparam logic [15:0] CMD_ADDR_A = 16'h5555;
  localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CMD_KEY1   = 8'hAA;
  localparam logic [7:0]  CMD_KEY2   = 8'h55;
  localparam logic [7:0]  CMD_ARM    = 8'hA0;
  localparam logic [7:0]  CMD_UNLOCK = 8'h80;
  localparam logic [7:0]  CMD_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_ARMED,
    SEQ_REL_A,
    SEQ_REL_B,
    SEQ_REL_C
  } seqStateT;

  typedef struct packed {
    logic commit;
    logic flipToggle;
    logic readEn;
    logic busy;
  } ctrlStrobesT;
endpackage

// File: rtl/nv_protect_ctrl.sv
module nv_protect_ctrl
  import nv_protect_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobesT       strobes
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic wrActive, wrActiveQ, wrStart, accept;
  logic rdActive, rdActiveQ, rdStart;
  logic busyQ;
  logic [CNT_W-1:0] cntQ;
  logic lockQ, setLock, clrLock, commit;
  seqStateT seqQ, seqNext;
  logic atA, atB, isKey1A, isKey2B, isArmA, isUnlockA, isClearA;

  assign wrActive = !ceN && !weN && oeN;
  assign rdActive = !ceN && !oeN && weN;
  assign wrStart  = wrActive && !wrActiveQ;
  assign rdStart  = rdActive && !rdActiveQ;
  assign accept   = wrStart && supplyOk && !busyQ;

  assign atA       = ({{(16 > ADDR_W ? 16 - ADDR_W : 0){1'b0}}, addr} == {{(ADDR_W > 16 ? ADDR_W - 16 : 0){1'b0}}, CMD_ADDR_A});
  assign atB       = ({{(16 > ADDR_W ? 16 - ADDR_W : 0){1'b0}}, addr} == {{(ADDR_W > 16 ? ADDR_W - 16 : 0){1'b0}}, CMD_ADDR_B});
  assign isKey1A   = atA && (wrData == CMD_KEY1);
  assign isKey2B   = atB && (wrData == CMD_KEY2);
  assign isArmA    = atA && (wrData == CMD_ARM);
  assign isUnlockA = atA && (wrData == CMD_UNLOCK);
  assign isClearA  = atA && (wrData == CMD_CLEAR);

  always_comb begin
    seqNext = seqQ;
    commit  = 1'b0;
    setLock = 1'b0;
    clrLock = 1'b0;
    if (accept) begin
      seqNext = SEQ_IDLE;
      unique case (seqQ)
        SEQ_IDLE:  if (isKey1A) seqNext = SEQ_KEY1; else commit = !lockQ;
        SEQ_KEY1:  if (isKey2B) seqNext = SEQ_KEY2; else commit = !lockQ;
        SEQ_KEY2: begin
          if (isArmA)         seqNext = SEQ_ARMED;
          else if (isUnlockA) seqNext = SEQ_REL_A;
          else                commit  = !lockQ;
        end
        SEQ_ARMED: begin
          commit  = 1'b1;
          setLock = 1'b1;
        end
        SEQ_REL_A: if (isKey1A) seqNext = SEQ_REL_B; else commit = !lockQ;
        SEQ_REL_B: if (isKey2B) seqNext = SEQ_REL_C; else commit = !lockQ;
        SEQ_REL_C: if (isClearA) clrLock = 1'b1; else commit = !lockQ;
        default:   seqNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActiveQ <= 1'b0;
      rdActiveQ <= 1'b0;
      seqQ      <= SEQ_IDLE;
      lockQ     <= 1'b0;
      busyQ     <= 1'b0;
      cntQ      <= '0;
    end else begin
      wrActiveQ <= wrActive;
      rdActiveQ <= rdActive;
      seqQ      <= supplyOk ? seqNext : SEQ_IDLE;
      if (setLock)      lockQ <= 1'b1;
      else if (clrLock) lockQ <= 1'b0;
      if (commit) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busyQ) begin
        if (cntQ == '0) busyQ <= 1'b0;
        else            cntQ  <= cntQ - 1'b1;
      end
    end
  end

  assign strobes.commit     = commit;
  assign strobes.flipToggle = rdStart && busyQ;
  assign strobes.readEn     = rdActive;
  assign strobes.busy       = busyQ;

  // R2
  commit_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (!ceN && !weN && oeN));
  // R3
  commit_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> supplyOk);
  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !busyQ);
  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(commit));
  // R13
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> $past(supplyOk && !commit));
endmodule

// File: rtl/nv_protect_array.sv
module nv_protect_array
  import nv_protect_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] memQ [MEM_DEPTH];
  logic toggleQ;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) memQ[i] <= '0;
      toggleQ <= 1'b0;
    end else begin
      if (strobes.commit) memQ[idx] <= wrData;
      if (strobes.flipToggle) toggleQ <= !toggleQ;
    end
  end

  always_comb begin
    word = memQ[idx];
    if (strobes.busy) word[TOGGLE_BIT] = toggleQ;
    rdData = strobes.readEn ? word : '0;
  end

  // R5
  busy_follows_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> strobes.busy);
  // R1
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readEn |-> (rdData == '0));
endmodule

// File: rtl/nv_protect_mem.sv
module nv_protect_mem
  import nv_protect_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int MEM_DEPTH    = 64,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              commitStrobe,
  output logic              busy
);
  localparam int IDX_W = $clog2(MEM_DEPTH);

  ctrlStrobesT strobes;

  nv_protect_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .supplyOk(supplyOk), .addr(addr), .wrData(wrData), .strobes(strobes)
  );

  nv_protect_array #(.MEM_DEPTH(MEM_DEPTH)) array_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(addr[IDX_W-1:0]),
    .wrData(wrData), .rdData(rdData)
  );

  assign commitStrobe = strobes.commit;
  assign busy         = strobes.busy;
endmodule

// File: tb/nv_protect_mem_tb.sv
module nv_protect_mem_tb_top;
  localparam int WC = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, supplyOk = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] wrData = '0, rdData;
  logic commitStrobe, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = !clk;

  nv_protect_mem #(.ADDR_W(15), .MEM_DEPTH(64), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .supplyOk(supplyOk), .addr(addr), .wrData(wrData), .rdData(rdData),
    .commitStrobe(commitStrobe), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one bus write; reports whether a commit pulse was seen
  task automatic busWrite(input logic [14:0] a, input logic [7:0] d, output bit saw,
                          input logic c = 0, input logic o = 1, input logic w = 0);
    @(negedge clk);
    addr = a; wrData = d; ceN = c; oeN = o; weN = w;
    #1 saw = commitStrobe;
    @(negedge clk);
    ceN = 1; oeN = 1; weN = 1;
  endtask

  task automatic busRead(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 0; oeN = 0; weN = 1;
    @(negedge clk);
    #1 d = rdData;
    ceN = 1; oeN = 1;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmdWrite(input logic [14:0] a, input logic [7:0] d, string req);
    bit s;
    busWrite(a, d, s);
    check(req, s, 0);
  endtask

  task automatic armPrefix(string req);
    cmdWrite(15'h5555, 8'hAA, req);
    cmdWrite(15'h2AAA, 8'h55, req);
    cmdWrite(15'h5555, 8'hA0, req);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 busy", busy, 0);
    check("R1 commit", commitStrobe, 0);
    check("R1 rdData idle", rdData, 0);
    busRead(15'h0003, d);
    check("R1 array cleared", d, 0);
  endtask

  task automatic testPlainWrite();
    bit s; int n; logic [7:0] d1, d2;
    busWrite(15'h0010, 8'h3C, s);
    check("R4 commit", s, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R5 busy length", n, WC);
    busRead(15'h0010, d1);
    busRead(15'h0010, d2);
    check("R4 readback", d1, 8'h3C);
    check("R7 stable read", d2, d1);
  endtask

  task automatic testBusyWindow();
    bit s; logic [7:0] r1, r2, d;
    busWrite(15'h0011, 8'h81, s);
    check("R4 commit second", s, 1);
    busWrite(15'h0012, 8'h77, s);
    check("R5 write during busy ignored", s, 0);
    busRead(15'h0011, r1);
    busRead(15'h0011, r2);
    check("R6 still busy", busy, 1);
    check("R6 bit6 inverts", r2[6], !r1[6]);
    busRead(15'h0011, r1);
    check("R6 bit6 inverts again", r1[6], !r2[6]);
    waitIdle();
    busRead(15'h0012, d);
    check("R5 ignored write left array", d, 8'h00);
    busRead(15'h0011, d);
    check("R7 true data after busy", d, 8'h81);
  endtask

  task automatic testHwInhibit();
    bit s; logic [7:0] d;
    busWrite(15'h0020, 8'h11, s, 0, 0, 0);
    check("R2 oeN low blocks", s, 0);
    busWrite(15'h0020, 8'h22, s, 1, 1, 0);
    check("R2 ceN high blocks", s, 0);
    busWrite(15'h0020, 8'h33, s, 0, 1, 1);
    check("R2 weN high blocks", s, 0);
    busRead(15'h0020, d);
    check("R2 array unchanged", d, 0);
    @(negedge clk) supplyOk = 0;
    busWrite(15'h0021, 8'h44, s);
    check("R3 low supply blocks", s, 0);
    @(negedge clk) supplyOk = 1;
    busRead(15'h0021, d);
    check("R3 array unchanged", d, 0);
  endtask

  task automatic testLock();
    bit s; logic [7:0] d;
    armPrefix("R8 prefix commits nothing");
    busWrite(15'h0030, 8'h5A, s);
    check("R8 armed write commits", s, 1);
    waitIdle();
    busRead(15'h0030, d);
    check("R8 armed data stored", d, 8'h5A);
    busWrite(15'h0031, 8'h99, s);
    check("R9 bare write ignored", s, 0);
    busRead(15'h0031, d);
    check("R9 array unchanged", d, 0);
    cmdWrite(15'h5555, 8'hAA, "R11 step one");
    busWrite(15'h0032, 8'h66, s);
    check("R11 wrong step aborts, locked write dropped", s, 0);
    busWrite(15'h5555, 8'hA0, s);
    check("R11 sequence not resumed", s, 0);
    busWrite(15'h0032, 8'h67, s);
    check("R11 following write still dropped", s, 0);
    @(negedge clk) supplyOk = 0;
    repeat (4) @(negedge clk);
    supplyOk = 1;
    busWrite(15'h0033, 8'h12, s);
    check("R12 lock survives supply loss", s, 0);
    armPrefix("R10 prefix");
    busWrite(15'h0034, 8'hC3, s);
    check("R10 locked armed write commits", s, 1);
    waitIdle();
    busWrite(15'h0035, 8'h01, s);
    check("R10 lock still set", s, 0);
  endtask

  task automatic testRelease();
    bit s; logic [7:0] d;
    cmdWrite(15'h5555, 8'hAA, "R13 release");
    cmdWrite(15'h2AAA, 8'h55, "R13 release");
    cmdWrite(15'h5555, 8'h80, "R13 release");
    cmdWrite(15'h5555, 8'hAA, "R13 release");
    cmdWrite(15'h2AAA, 8'h55, "R13 release");
    cmdWrite(15'h5555, 8'h20, "R13 release");
    busWrite(15'h0036, 8'hE7, s);
    check("R13 plain write after release", s, 1);
    waitIdle();
    busRead(15'h0036, d);
    check("R13 data stored", d, 8'hE7);
    cmdWrite(15'h5555, 8'hAA, "R11 unlocked step");
    busWrite(15'h0037, 8'h4B, s);
    check("R11 aborting write taken as plain write", s, 1);
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPlainWrite();
    testBusyWindow();
    testHwInhibit();
    testLock();
    testRelease();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule